// File: doc/BRIEF.md
# Double-Buffered Serial DAC Loader

This block is the digital front end of a serial digital-to-analog converter. An external master sends 16-bit frames over three wires: a serial clock, an active-low frame sync and a data line. Each frame carries four ignored bits, then a 12-bit code sent MSB first. The block collects the code in a holding register (the input latch). A separate active-low load strobe decides when that code moves to the output register (the DAC latch). Only the DAC latch drives the converter.

The block runs from a system clock at least four times faster than the serial clock. Every external input passes through a two-flop synchroniser before any edge is detected. Whether the output register is written depends on where the load strobe's low phase falls relative to a frame:

- A strobe fall while no frame is active copies the holding register to the output.
- A strobe fall inside a frame does nothing at that moment.
- If the strobe is low when the 16th falling serial edge arrives, the output is written then.

Each write of the output register produces a one-cycle pulse on `dac_upd`.

Top module: `sdac_loader`

## Requirements
- R1: A falling edge on `fsync_n` starts a frame. The next 16 falling edges of `sclk` each sample `sdata`, and the 16th ends the frame.
- R2: The 12 bits sampled at falling edges 5 to 16 form the code, MSB first. The first four sampled bits never affect any register.
- R3: `dac_q` changes only when the output register is written. A completed frame updates the input latch but leaves `dac_q` as it was, unless R5 applies.
- R4: A falling edge of `load_n` while no frame is active copies the input latch to `dac_q`.
- R5: If `load_n` is low at the 16th falling `sclk` edge, `dac_q` takes the new code at the end of that frame. This holds whether `load_n` was held low through the whole frame or fell part way through it.
- R6: A falling edge of `load_n` inside a frame causes no write by itself. If `load_n` returns high before the frame ends, that frame writes nothing to `dac_q`.
- R7: A new `fsync_n` falling edge during a frame restarts the bit count. The partial frame is dropped.
- R8: `dac_upd` is high for exactly one system clock cycle per write of `dac_q`, and at no other time.
- R9: While `rst_n` is low, `dac_q`, the input latch and `dac_upd` are zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sclk | input | 1 | External serial clock, asynchronous |
| fsync_n | input | 1 | Active-low frame sync, asynchronous |
| sdata | input | 1 | Serial data, sampled on falling `sclk` |
| load_n | input | 1 | Active-low load strobe, asynchronous |
| dac_q | output | 12 | Output (DAC) latch contents |
| dac_upd | output | 1 | One-cycle pulse on each output latch write |

## Verification
If the bit counter is wrong, the output code at the end of a frame comes out shifted or truncated. This appears within about four system cycles of the 16th serial fall. A stale frame-active flag shows up in one of two ways. A load pulse between frames may produce no `dac_upd`. Or a strobe fall inside a frame may produce an extra pulse that carries the previous code. A holding register that is corrupted stays hidden until the next load. The bench therefore follows every frame that was loaded without a strobe with an explicit load pulse, and compares the output code at that point.

// File: rtl/sdac_loader.sv
module sdac_loader #(
  parameter int CODE_W      = 12,
  parameter int FRAME_LEN   = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sclk,
  input  logic              fsync_n,
  input  logic              sdata,
  input  logic              load_n,
  output logic [CODE_W-1:0] dac_q,
  output logic              dac_upd
);
  localparam int CW = $clog2(FRAME_LEN);
  localparam logic [CW-1:0] LAST = CW'(FRAME_LEN - 1);
  localparam logic [3:0] IDLE = 4'b1011;

  logic [3:0] sync_q [SYNC_STAGES];
  logic [3:0] prev_q;
  logic [3:0] now_s;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < SYNC_STAGES; i++) sync_q[i] <= IDLE;
      prev_q <= IDLE;
    end else begin
      sync_q[0] <= {load_n, sdata, fsync_n, sclk};
      for (int i = 1; i < SYNC_STAGES; i++) sync_q[i] <= sync_q[i-1];
      prev_q <= sync_q[SYNC_STAGES-1];
    end
  end

  assign now_s = sync_q[SYNC_STAGES-1];

  logic sclk_fall, fs_fall, ld_fall, sd_s, ld_s;
  assign sclk_fall = prev_q[0] & ~now_s[0];
  assign fs_fall   = prev_q[1] & ~now_s[1];
  assign ld_fall   = prev_q[3] & ~now_s[3];
  assign sd_s      = now_s[2];
  assign ld_s      = now_s[3];

  logic              busy;
  logic [CW-1:0]     bit_cnt;
  logic [CODE_W-1:0] shreg, in_latch, next_word;
  logic              done;

  assign next_word = {shreg[CODE_W-2:0], sd_s};
  assign done      = busy & ~fs_fall & sclk_fall & (bit_cnt == LAST);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy     <= 1'b0;
      bit_cnt  <= '0;
      shreg    <= '0;
      in_latch <= '0;
    end else if (fs_fall) begin
      busy    <= 1'b1;
      bit_cnt <= '0;
    end else if (busy && sclk_fall) begin
      shreg   <= next_word;
      bit_cnt <= bit_cnt + 1'b1;
      if (bit_cnt == LAST) begin
        busy     <= 1'b0;
        in_latch <= next_word;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      dac_q   <= '0;
      dac_upd <= 1'b0;
    end else begin
      dac_upd <= 1'b0;
      if (done && !ld_s) begin
        dac_q   <= next_word;
        dac_upd <= 1'b1;
      end else if (ld_fall && !busy) begin
        dac_q   <= in_latch;
        dac_upd <= 1'b1;
      end
    end
  end
endmodule

module sdac_loader_chk #(
  parameter int CODE_W = 12,
  parameter int CW     = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic [CODE_W-1:0] dac_q,
  input logic              dac_upd,
  input logic              ld_s,
  input logic              busy,
  input logic [CW-1:0]     bit_cnt
);
  AST_UPD_SINGLE: assert property (@(posedge clk) disable iff (!rst_n) dac_upd |=> !dac_upd); // R8
  AST_DAC_HOLD: assert property (@(posedge clk) disable iff (!rst_n) !dac_upd |-> $stable(dac_q)); // R3
  AST_WRITE_NEEDS_LOAD: assert property (@(posedge clk) disable iff (!rst_n) dac_upd |-> !$past(ld_s)); // R6
  AST_IDLE_COUNT: assert property (@(posedge clk) disable iff (!rst_n) !busy |=> (!busy || bit_cnt == '0)); // R1
  AST_RESET_CLEAR: assert property (@(posedge clk) !rst_n |=> (dac_q == '0 && !dac_upd)); // R9
endmodule

bind sdac_loader sdac_loader_chk #(.CODE_W(CODE_W), .CW(CW)) u_chk (
  .clk(clk), .rst_n(rst_n), .dac_q(dac_q), .dac_upd(dac_upd),
  .ld_s(ld_s), .busy(busy), .bit_cnt(bit_cnt)
);

// File: tb/sdac_loader_tb.sv
module sdac_loader_tb;
  logic clk = 1'b0, rst_n = 1'b0;
  logic sclk = 1'b0, fsync_n = 1'b1, sdata = 1'b0, load_n = 1'b1;
  logic [11:0] dac_q;
  logic dac_upd;

  sdac_loader u_dut (.clk(clk), .rst_n(rst_n), .sclk(sclk), .fsync_n(fsync_n),
                     .sdata(sdata), .load_n(load_n), .dac_q(dac_q), .dac_upd(dac_upd));

  always #2 clk = ~clk;

  int checks = 0, failures = 0, upd_cnt = 0, upd_exp = 0;
  logic [11:0] in_exp = '0, dac_exp = '0;

  always @(negedge clk) if (rst_n && dac_upd) upd_cnt++;

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic send(input logic [15:0] w, input int nbits, input int lo_at, input int hi_at);
    fsync_n = 1'b0; cyc(4);
    for (int i = 0; i < nbits; i++) begin
      sdata = w[15-i];
      if (i == lo_at) load_n = 1'b0;
      if (i == hi_at) load_n = 1'b1;
      sclk = 1'b1; cyc(4);
      sclk = 1'b0; cyc(4);
    end
    fsync_n = 1'b1; cyc(8);
  endtask

  task automatic pulse_load();
    load_n = 1'b0; cyc(8);
    dac_exp = in_exp; upd_exp++;
    load_n = 1'b1; cyc(8);
  endtask

  initial begin
    cyc(200000);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    cyc(5);
    chk("R9 reset dac_q", dac_q, 0);
    chk("R9 reset upd", dac_upd, 0);
    rst_n = 1'b1; cyc(10);

    send(16'hA5C3, 16, -1, -1); in_exp = 12'h5C3;
    chk("R3 frame w/o load keeps dac_q", dac_q, 0);
    chk("R3 no pulse", upd_cnt, upd_exp);
    pulse_load();
    chk("R4 idle load copies", dac_q, dac_exp);
    chk("R8 one pulse", upd_cnt, upd_exp);

    load_n = 1'b0; cyc(8); dac_exp = in_exp; upd_exp++;
    send(16'h3ABC, 16, -1, -1); in_exp = 12'hABC; dac_exp = in_exp; upd_exp++;
    chk("R5 held low updates at end", dac_q, dac_exp);
    chk("R8 held low pulse count", upd_cnt, upd_exp);
    load_n = 1'b1; cyc(8);

    send(16'hC123, 16, 6, -1); in_exp = 12'h123; dac_exp = in_exp; upd_exp++;
    chk("R5 fell mid stays low", dac_q, dac_exp);
    chk("R6 mid fall no extra write", upd_cnt, upd_exp);
    load_n = 1'b1; cyc(8);

    send(16'h0F0E, 16, 5, 10); in_exp = 12'hF0E;
    chk("R6 fall and rise in frame no write", dac_q, dac_exp);
    chk("R6 no pulse", upd_cnt, upd_exp);
    pulse_load();
    chk("R4 later idle load", dac_q, dac_exp);

    send(16'hFFFF, 5, -1, -1);
    send(16'h5246, 16, -1, -1); in_exp = 12'h246;
    pulse_load();
    chk("R7 restart drops partial", dac_q, dac_exp);
    chk("R7 pulse count", upd_cnt, upd_exp);

    for (int k = 0; k < 20; k++) begin
      logic [15:0] w;
      w = 16'(k * 16'h1357 + 16'h0ACE) ^ 16'(k << 12);
      send(w, 16, -1, -1); in_exp = w[11:0];
      pulse_load();
      chk("R2 payload sweep", dac_q, dac_exp);
      chk("R1 sweep count", upd_cnt, upd_exp);
    end

    send(16'hF800, 16, -1, -1); in_exp = 12'h800; pulse_load();
    send(16'h0800, 16, -1, -1); pulse_load();
    chk("R2 top nibble ignored", dac_q, 12'h800);

    rst_n = 1'b0; cyc(4);
    chk("R9 reset clears dac_q", dac_q, 0);
    rst_n = 1'b1; cyc(8);
    in_exp = '0; pulse_load();
    chk("R9 reset clears input latch", dac_q, 0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule